// File: doc/BRIEF.md
# Multiplexed LED Scan Controller

This block refreshes a multiplexed LED sign whose pixels sit behind external serial-in, parallel-out shift-register chains. For each scanline it reads one word per bit position from a synchronous frame buffer. Every bit of that word goes to its own chain, so all chains fill in parallel on a shared shift clock. The block then pulses a latch, selects one row and lights it for a programmable dwell time before it moves to the next scanline. The number of scanlines can be any value from 1, the static case where one row is lit all the time, up to a parameter limit. Values that are not powers of two are allowed.

The block has two modes. In latched mode the chains have output registers, so the next scanline is shifted in while the current one is on display. In latchless mode the chain outputs follow the shift stages directly, so output enable stays low for the whole shift. The shift clock runs at the system clock divided by twice a programmable half-period. Row outputs can be active high or active low. The configuration inputs must only change while reset is asserted.

Top module: `led_scan_ctrl`

## Requirements
- R1: While reset is asserted, and until the first latch pulse, no row is active. During reset `sh_oe`, `sh_latch`, `sh_clk`, `frame_start` and `sh_data` are all low. The first scanline loaded after reset is line 0.
- R2: A scanline load starts with one fetch cycle in which `sh_clk` is low. Each of the `cfg_len` bits then follows: `sh_clk` is low for `cfg_half` cycles and then high for `cfg_half` cycles. During both phases `sh_data` holds the frame-buffer word at address {line, bit index}, with the line in the upper bits and the bit index in the lower clog2(MAX_LEN) bits. `sh_data` never changes in the cycle where `sh_clk` rises.
- R3: Scanlines are shown in order 0, 1, ..., `cfg_lines`-1 and then wrap to 0. This holds for any `cfg_lines` from 1 to MAX_LINES.
- R4: In latched mode (`cfg_latchless`=0), the next scanline is shifted while the current row is lit. The lit period lasts max(1+2·`cfg_half`·`cfg_len`, `cfg_dwell`) cycles. A new shift never starts while one is still running.
- R5: In latchless mode the lit period lasts exactly `cfg_dwell` cycles. The next scanline is then shifted in with `sh_oe` low for the whole shift.
- R6: Between two lit periods there are three cycles with `sh_oe` low. In the first the old row is still selected. The second carries a one-cycle `sh_latch` pulse. In the third the new row is selected. The row selection therefore never changes when `sh_oe` is high in that cycle or the one before it.
- R7: `cfg_row_active_low`=1 inverts every `row_sel` bit. At most one row is at its active level at any time.
- R8: `frame_start` is high for one cycle, the blank cycle in which row 0 first becomes selected. `sh_oe` is low in that cycle.
- R9: With `cfg_lines`=1, row 0 stays active continuously after the first latch pulse, and `frame_start` occurs at every refresh.
- R10: `sh_clk` is low whenever no shift is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_lines | input | clog2(MAX_LINES+1) | Number of scanlines (1..MAX_LINES) |
| cfg_len | input | clog2(MAX_LEN+1) | Bits per chain per scanline (1..MAX_LEN) |
| cfg_half | input | DIV_W | Shift-clock half-period in system cycles (>=1) |
| cfg_dwell | input | DWELL_W | Minimum lit cycles per row (>=1) |
| cfg_latchless | input | 1 | 1: latchless chains, blank while shifting |
| cfg_row_active_low | input | 1 | 1: row outputs are active low |
| fb_rd | output | 1 | Frame-buffer read strobe |
| fb_addr | output | clog2(MAX_LINES)+clog2(MAX_LEN) | Frame-buffer address {line, bit index} |
| fb_data | input | CHAINS | Read word, valid the cycle after `fb_rd` |
| sh_data | output | CHAINS | One serial data bit per chain |
| sh_clk | output | 1 | Shared shift clock |
| sh_latch | output | 1 | One-cycle storage-register latch pulse |
| sh_oe | output | 1 | Chain output enable, high = LEDs may light |
| row_sel | output | MAX_LINES | Row-select lines |
| frame_start | output | 1 | Pulse as scanline 0 is selected |

## Verification
The hardest case to reach from the ports is the latched overlap: a shift that is still running when the dwell time ends must hold the row lit, and a dwell that outlasts the shift must hold it too. The stimulus runs latched configurations on both sides of that boundary, with the dwell below and above 1+2·half·len. It also covers non-power-of-two and single-line multiplex factors. A behavioural model of the expected waveform predicts the row, enable, latch, clock and data for every cycle.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [2:0] {
    SQ_BOOT  = 3'd0,
    SQ_LOAD  = 3'd1,
    SQ_SHOW  = 3'd2,
    SQ_PRE   = 3'd3,
    SQ_LATCH = 3'd4,
    SQ_POST  = 3'd5
  } sq_state_t;
endpackage

// File: rtl/lsc_shifter.sv
// Parallel chain loader: one fetch cycle, then cfg_len bits of 2*cfg_half cycles.
module lsc_shifter #(
  parameter int CHAINS    = 8,
  parameter int MAX_LEN   = 128,
  parameter int MAX_LINES = 16,
  parameter int DIV_W     = 8,
  localparam int BIT_W    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int LINE_W   = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1,
  localparam int ADDR_W   = LINE_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              start_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              fb_rd_o,
  output logic [ADDR_W-1:0] fb_addr_o,
  input  logic [CHAINS-1:0] fb_data_i,
  output logic [CHAINS-1:0] sdata_o,
  output logic              sclk_o,
  output logic              busy_o,
  output logic              last_o
);
  logic              busy_q, busy_d, phase_q, phase_d, rd_q;
  logic [DIV_W-1:0]  half_q, half_d, half_m1;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic [LEN_W-1:0]  len_m1;
  logic [CHAINS-1:0] hold_q;
  logic              phase_end, bit_end;

  assign half_m1   = (cfg_half == '0) ? '0 : cfg_half - DIV_W'(1);
  assign len_m1    = (cfg_len == '0) ? '0 : cfg_len - LEN_W'(1);
  assign phase_end = (half_q == half_m1);
  assign bit_end   = (LEN_W'(bit_q) == len_m1);
  assign last_o    = busy_q & phase_q & phase_end & bit_end;
  assign fb_rd_o   = start_i | (busy_q & phase_q & phase_end & ~bit_end);
  assign fb_addr_o = start_i ? {line_i, {BIT_W{1'b0}}} : {line_q, bit_q + BIT_W'(1)};
  // Word read in the previous cycle goes straight to the pins, then is held.
  assign sdata_o   = rd_q ? fb_data_i : hold_q;
  assign sclk_o    = busy_q & phase_q;
  assign busy_o    = busy_q;

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    half_d  = half_q;
    bit_d   = bit_q;
    line_d  = line_q;
    if (start_i) begin
      busy_d  = 1'b1;
      phase_d = 1'b0;
      half_d  = '0;
      bit_d   = '0;
      line_d  = line_i;
    end else if (busy_q) begin
      if (phase_end) begin
        half_d = '0;
        if (!phase_q) begin
          phase_d = 1'b1;
        end else begin
          phase_d = 1'b0;
          if (bit_end) busy_d = 1'b0;
          else         bit_d  = bit_q + BIT_W'(1);
        end
      end else begin
        half_d = half_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      half_q  <= '0;
      bit_q   <= '0;
      line_q  <= '0;
      rd_q    <= 1'b0;
      hold_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      half_q  <= half_d;
      bit_q   <= bit_d;
      line_q  <= line_d;
      rd_q    <= fb_rd_o;
      if (rd_q) hold_q <= fb_data_i;
    end
  end

  assert_data_stable_at_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(sdata_o));
  assert_no_restart_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);
endmodule

// File: rtl/lsc_seq.sv
// Scan sequencer: load, lit period, blank/latch/blank row change.
module lsc_seq
  import lsc_pkg::*;
#(
  parameter int MAX_LINES = 16,
  parameter int DWELL_W   = 16,
  localparam int LINE_W   = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1,
  localparam int LINES_W  = $clog2(MAX_LINES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES_W-1:0] cfg_lines,
  input  logic [DWELL_W-1:0] cfg_dwell,
  input  logic               cfg_latchless,
  input  logic               shf_last_i,
  output logic               start_o,
  output logic [LINE_W-1:0]  load_line_o,
  output logic               oe_o,
  output logic               latch_o,
  output logic               row_on_o,
  output logic [LINE_W-1:0]  row_idx_o,
  output logic               frame_start_o
);
  sq_state_t          state_q, state_d;
  logic               start_q, start_d, row_on_q, row_on_d, shdone_q, shdone_d;
  logic [LINE_W-1:0]  load_q, load_d, row_q, row_d, load_next;
  logic [DWELL_W-1:0] dwell_q, dwell_d, dwell_m1;
  logic               dwell_hit, stay_show;

  assign dwell_m1  = (cfg_dwell == '0) ? '0 : cfg_dwell - DWELL_W'(1);
  assign dwell_hit = (dwell_q >= dwell_m1);
  assign load_next = ((LINES_W'(load_q) + LINES_W'(1)) >= cfg_lines) ? '0 : load_q + LINE_W'(1);

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_BOOT:  state_d = SQ_LOAD;
      SQ_LOAD:  if (shf_last_i) state_d = SQ_PRE;
      SQ_SHOW: begin
        if (cfg_latchless) begin
          if (dwell_hit) state_d = SQ_LOAD;
        end else if (dwell_hit && (shdone_q || shf_last_i)) begin
          state_d = SQ_PRE;
        end
      end
      SQ_PRE:   state_d = SQ_LATCH;
      SQ_LATCH: state_d = SQ_POST;
      SQ_POST:  state_d = SQ_SHOW;
      default:  state_d = SQ_BOOT;
    endcase
  end

  always_comb begin
    stay_show = (state_q == SQ_SHOW) && (state_d == SQ_SHOW);
    start_d   = ((state_d == SQ_LOAD) && (state_q != SQ_LOAD)) ||
                ((state_d == SQ_SHOW) && (state_q != SQ_SHOW) && !cfg_latchless);
    dwell_d   = '0;
    shdone_d  = 1'b0;
    if (stay_show) begin
      dwell_d  = (dwell_q == '1) ? dwell_q : dwell_q + DWELL_W'(1);
      shdone_d = shdone_q | shf_last_i;
    end
    load_d   = load_q;
    row_d    = row_q;
    row_on_d = row_on_q;
    if (state_q == SQ_LATCH) begin
      row_d    = load_q;
      row_on_d = 1'b1;
      load_d   = load_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SQ_BOOT;
      start_q  <= 1'b0;
      shdone_q <= 1'b0;
      dwell_q  <= '0;
      load_q   <= '0;
      row_q    <= '0;
      row_on_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      start_q  <= start_d;
      shdone_q <= shdone_d;
      dwell_q  <= dwell_d;
      load_q   <= load_d;
      row_q    <= row_d;
      row_on_q <= row_on_d;
    end
  end

  assign start_o       = start_q;
  assign load_line_o   = load_q;
  assign oe_o          = (state_q == SQ_SHOW);
  assign latch_o       = (state_q == SQ_LATCH);
  assign row_on_o      = row_on_q;
  assign row_idx_o     = row_q;
  assign frame_start_o = (state_q == SQ_POST) && (row_q == '0);

  assert_latch_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |=> !latch_o);
  assert_frame_start_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> !oe_o);
  assert_lit_needs_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> row_on_o);
endmodule

// File: rtl/lsc_row_drv.sv
// One-hot row decoder with selectable active level.
module lsc_row_drv #(
  parameter int MAX_LINES = 16,
  localparam int LINE_W   = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 row_on_i,
  input  logic [LINE_W-1:0]    row_idx_i,
  input  logic                 active_low_i,
  output logic [MAX_LINES-1:0] row_o
);
  for (genvar g = 0; g < MAX_LINES; g++) begin : g_row
    assign row_o[g] = (row_on_i && (row_idx_i == LINE_W'(g))) ^ active_low_i;
  end

  assert_one_row_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_o ^ {MAX_LINES{active_low_i}}));
endmodule

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl #(
  parameter int CHAINS    = 8,
  parameter int MAX_LEN   = 128,
  parameter int MAX_LINES = 16,
  parameter int DIV_W     = 8,
  parameter int DWELL_W   = 16,
  localparam int BIT_W    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int LINE_W   = (MAX_LINES > 1) ? $clog2(MAX_LINES) : 1,
  localparam int LINES_W  = $clog2(MAX_LINES + 1),
  localparam int ADDR_W   = LINE_W + BIT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LINES_W-1:0]   cfg_lines,
  input  logic [LEN_W-1:0]     cfg_len,
  input  logic [DIV_W-1:0]     cfg_half,
  input  logic [DWELL_W-1:0]   cfg_dwell,
  input  logic                 cfg_latchless,
  input  logic                 cfg_row_active_low,
  output logic                 fb_rd,
  output logic [ADDR_W-1:0]    fb_addr,
  input  logic [CHAINS-1:0]    fb_data,
  output logic [CHAINS-1:0]    sh_data,
  output logic                 sh_clk,
  output logic                 sh_latch,
  output logic                 sh_oe,
  output logic [MAX_LINES-1:0] row_sel,
  output logic                 frame_start
);
  logic              start, shf_busy, shf_last, row_on;
  logic [LINE_W-1:0] load_line, row_idx;

  lsc_seq #(.MAX_LINES(MAX_LINES), .DWELL_W(DWELL_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .cfg_lines(cfg_lines), .cfg_dwell(cfg_dwell),
    .cfg_latchless(cfg_latchless), .shf_last_i(shf_last), .start_o(start),
    .load_line_o(load_line), .oe_o(sh_oe), .latch_o(sh_latch), .row_on_o(row_on),
    .row_idx_o(row_idx), .frame_start_o(frame_start)
  );

  lsc_shifter #(.CHAINS(CHAINS), .MAX_LEN(MAX_LEN), .MAX_LINES(MAX_LINES), .DIV_W(DIV_W)) shf_i (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_len(cfg_len),
    .start_i(start), .line_i(load_line), .fb_rd_o(fb_rd), .fb_addr_o(fb_addr),
    .fb_data_i(fb_data), .sdata_o(sh_data), .sclk_o(sh_clk), .busy_o(shf_busy),
    .last_o(shf_last)
  );

  lsc_row_drv #(.MAX_LINES(MAX_LINES)) row_i (
    .clk(clk), .rst_n(rst_n), .row_on_i(row_on), .row_idx_i(row_idx),
    .active_low_i(cfg_row_active_low), .row_o(row_sel)
  );

  assert_row_switch_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_sel) |-> (!sh_oe && !$past(sh_oe)));
  assert_latchless_dark_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_latchless && shf_busy) |-> !sh_oe);
endmodule

// File: tb/led_scan_ctrl_tb_top.sv
`timescale 1ns/1ps
module led_scan_ctrl_tb_top;
  localparam int CHAINS = 8, MAX_LEN = 128, MAX_LINES = 16, DIV_W = 8, DWELL_W = 16;
  localparam int BIT_W = $clog2(MAX_LEN), LEN_W = $clog2(MAX_LEN + 1);
  localparam int LINE_W = $clog2(MAX_LINES), LINES_W = $clog2(MAX_LINES + 1);
  localparam int ADDR_W = LINE_W + BIT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LINES_W-1:0] cfg_lines = LINES_W'(1);
  logic [LEN_W-1:0]   cfg_len = LEN_W'(1);
  logic [DIV_W-1:0]   cfg_half = DIV_W'(1);
  logic [DWELL_W-1:0] cfg_dwell = DWELL_W'(1);
  logic cfg_latchless = 1'b0, cfg_row_active_low = 1'b0;
  logic fb_rd, sh_clk, sh_latch, sh_oe, frame_start;
  logic [ADDR_W-1:0] fb_addr;
  logic [CHAINS-1:0] fb_data = '0, sh_data;
  logic [MAX_LINES-1:0] row_sel;

  int n_cmp = 0, n_bad = 0;
  int s_cyc;
  int cur_row;
  logic [CHAINS-1:0] cur_sd;
  string scen = "";

  always #4 clk = ~clk;

  led_scan_ctrl #(.CHAINS(CHAINS), .MAX_LEN(MAX_LEN), .MAX_LINES(MAX_LINES),
                  .DIV_W(DIV_W), .DWELL_W(DWELL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_lines(cfg_lines), .cfg_len(cfg_len),
    .cfg_half(cfg_half), .cfg_dwell(cfg_dwell), .cfg_latchless(cfg_latchless),
    .cfg_row_active_low(cfg_row_active_low), .fb_rd(fb_rd), .fb_addr(fb_addr),
    .fb_data(fb_data), .sh_data(sh_data), .sh_clk(sh_clk), .sh_latch(sh_latch),
    .sh_oe(sh_oe), .row_sel(row_sel), .frame_start(frame_start)
  );

  function automatic logic [CHAINS-1:0] pat(input int a);
    return CHAINS'((a * 37 + 11) ^ (a >> 2));
  endfunction

  // Synchronous frame-buffer model: one cycle read latency.
  always @(posedge clk) if (fb_rd) fb_data <= pat(int'(fb_addr));

  task automatic chk(input bit e_oe, input bit e_lat, input bit e_fs, input bit e_sclk,
                     input logic [CHAINS-1:0] e_sd, input int e_row, input string req);
    logic [MAX_LINES-1:0] e_rows;
    @(negedge clk);
    e_rows = '0;
    if (e_row >= 0) e_rows[e_row] = 1'b1;
    e_rows = e_rows ^ {MAX_LINES{cfg_row_active_low}};
    n_cmp++;
    if (sh_oe !== e_oe || sh_latch !== e_lat || frame_start !== e_fs || sh_clk !== e_sclk ||
        sh_data !== e_sd || row_sel !== e_rows) begin
      n_bad++;
      $display("FAIL %s [%s] t=%0t actual oe=%b lat=%b fs=%b clk=%b d=%h rows=%h expected oe=%b lat=%b fs=%b clk=%b d=%h rows=%h",
               req, scen, $time, sh_oe, sh_latch, frame_start, sh_clk, sh_data, row_sel,
               e_oe, e_lat, e_fs, e_sclk, e_sd, e_rows);
    end
  endtask

  // Expected shift waveform for one line over n cycles (fetch, bits, then idle).
  task automatic run_shift(input int line, input int n, input bit e_oe, input string req);
    for (int i = 0; i < n; i++) begin
      bit sc = 1'b0;
      if (i > 0 && i < s_cyc) begin
        int j = i - 1;
        int b = j / (2 * int'(cfg_half));
        sc = (j % (2 * int'(cfg_half))) >= int'(cfg_half);
        cur_sd = pat((line << BIT_W) | b);
      end
      chk(e_oe, 1'b0, 1'b0, sc, cur_sd, cur_row, req);
    end
  endtask

  task automatic row_change(input int nr);
    chk(1'b0, 1'b0, 1'b0, 1'b0, cur_sd, cur_row, "R6 R10");
    chk(1'b0, 1'b1, 1'b0, 1'b0, cur_sd, cur_row, "R6");
    cur_row = nr;
    chk(1'b0, 1'b0, nr == 0, 1'b0, cur_sd, cur_row, "R3 R8");
  endtask

  task automatic run_cfg(input int lines, input int len, input int half, input int dwell,
                         input bit latchless, input bit pol, input int shows, input string nm);
    int ld;
    scen = nm;
    rst_n = 1'b0;
    cfg_lines = LINES_W'(lines);
    cfg_len = LEN_W'(len);
    cfg_half = DIV_W'(half);
    cfg_dwell = DWELL_W'(dwell);
    cfg_latchless = latchless;
    cfg_row_active_low = pol;
    repeat (2) @(negedge clk);
    cur_row = -1;
    cur_sd = '0;
    chk(1'b0, 1'b0, 1'b0, 1'b0, '0, -1, "R1 R7");
    rst_n = 1'b1;
    s_cyc = 1 + 2 * half * len;
    ld = 0;
    run_shift(0, s_cyc, 1'b0, "R1 R2");
    for (int k = 0; k < shows; k++) begin
      int nr = ld;
      ld = (ld + 1) % lines;
      row_change(nr);
      if (!latchless) begin
        run_shift(ld, (s_cyc > dwell) ? s_cyc : dwell, 1'b1, "R4 R2");
      end else begin
        for (int d = 0; d < dwell; d++) chk(1'b1, 1'b0, 1'b0, 1'b0, cur_sd, cur_row, "R5");
        run_shift(ld, s_cyc, 1'b0, "R5 R2");
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog [%s] actual run still going expected finished", scen);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    run_cfg(5, 6, 1, 4, 1'b0, 1'b0, 12, "R3 latched five lines, dwell below shift");
    run_cfg(5, 3, 2, 40, 1'b0, 1'b1, 11, "R4 R7 latched, dwell above shift, active low");
    run_cfg(4, 4, 2, 20, 1'b1, 1'b1, 10, "R5 R7 latchless four lines active low");
    run_cfg(1, 3, 1, 30, 1'b0, 1'b0, 5, "R9 static single line");
    run_cfg(1, 2, 1, 3, 1'b1, 1'b0, 4, "R9 static latchless");
    run_cfg(16, 2, 3, 1, 1'b0, 1'b0, 20, "R3 sixteen lines wrap");
    run_cfg(2, MAX_LEN, 1, 5, 1'b1, 1'b0, 4, "R2 full chain length");
    run_cfg(3, 1, 1, 2, 1'b0, 1'b1, 7, "R2 one bit per line");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule